// File: doc/BRIEF.md
# Voice Activity LED Driver

This block lights four indicator LEDs, one for each of three synthesizer voices and one for sample playback. Each voice supplies an 8-bit envelope level and a gate bit. Sample playback supplies a level and a start bit of the same kind. The LEDs show which channels are sounding and roughly how loud each one is.

Two display styles are available, and the style can be changed at any time. In the first, each channel adds its level into a wrapping accumulator on every clock. A carry out of that addition lights the LED for one cycle, so the duty cycle follows the level. In the second, a rising gate lights the LED fully for a hold time counted in external tick pulses. After that the LED shows half brightness while the level is non-zero and goes dark once the level reaches zero. An invert control flips all four outputs, so the LEDs can be wired from the supply to the pin and driven low.

Top module: `act_led_drv`

## Requirements
- R1: There are four outputs, `led_o[0..2]` for voices 0..2 and `led_o[3]` for sample playback. While reset is asserted, and immediately after it, every LED is dark, so each output equals `inv_i`.
- R2: In accumulate mode (`mode_i`=0), each channel adds its level into an 8-bit wrapping accumulator at every clock edge. The LED is lit during the cycle that follows an edge at which that 9-bit sum reached 256 or more.
- R3: A level of 0 never lights the LED in accumulate mode. A level of 255 lights it in exactly 255 of any 256 consecutive cycles, and a level of 128 lights it in 128 of them.
- R4: `mode_i` (0 = accumulate, 1 = hold) and `inv_i` act on the outputs combinationally, in the same cycle. Both display engines keep running whichever mode is selected.
- R5: In hold mode, a gate seen high at a clock edge after being low at the previous edge is a rising edge. The LED is then lit continuously from the cycle after that edge.
- R6: The full-brightness phase ends at the edge where the HOLD_TICKS-th `tick_i` pulse after the rising edge is sampled. A tick sampled on the same edge as the rising edge is not counted. At the end of the phase, the channel moves to half brightness if its level is non-zero at that edge, and otherwise goes dark.
- R7: In half brightness, the LED is lit in the cycles where a shared phase bit is 1. That bit is 0 after reset and flips at every clock edge. A level of 0 sampled at an edge during half brightness turns the channel dark, and it stays dark until the next rising gate edge.
- R8: A rising gate edge in any phase (dark, half or full) returns the channel to full brightness and restarts the hold count.
- R9: With `inv_i`=1, every output is the complement of the lit state that R1 to R8 define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle time-base pulse for the hold count |
| voice_env_i | input | NVOICE*ENV_W | Envelope levels, voice 0 in the low bits |
| voice_gate_i | input | NVOICE | Gate bits, one per voice |
| digi_lvl_i | input | ENV_W | Sample playback activity level |
| digi_gate_i | input | 1 | Sample playback start bit |
| mode_i | input | 1 | Display style: 0 accumulate, 1 hold |
| inv_i | input | 1 | 1 drives the LEDs active-low |
| led_o | output | NVOICE+1 | LED pins, the sample channel in the top bit |

## Verification
The hardest state to reach from the ports is the end of the hold period. To get there, a gate must have risen, the required number of ticks must have passed without a new rising edge, and the level at that exact edge must be zero or non-zero. The stimulus runs the tick as a periodic pulse and raises gates on chosen channels with the levels set beforehand. It then changes levels and re-raises gates during the full and half phases, so that the switch to half brightness, the direct drop to dark, and both kinds of retrigger are all covered. A behavioural model is compared with the outputs every cycle, in both modes and both polarities.

// File: rtl/act_led_pkg.sv
package act_led_pkg;

  typedef enum logic [1:0] {
    HS_OFF  = 2'd0,
    HS_FULL = 2'd1,
    HS_HALF = 2'd2
  } hold_st_t;

endpackage

// File: rtl/act_led_pwm.sv
module act_led_pwm #(
  parameter int ENV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENV_W-1:0] env_i,
  output logic             lit_o
);

  logic [ENV_W-1:0] acc_q, acc_d;
  logic             lit_q, carry_d;

  // Wrapping accumulator; the carry becomes the lit bit for the next cycle
  always_comb begin
    {carry_d, acc_d} = {1'b0, acc_q} + {1'b0, env_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      lit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      lit_q <= carry_d;
    end
  end

  assign lit_o = lit_q;

endmodule

// File: rtl/act_led_hold.sv
module act_led_hold
  import act_led_pkg::*;
#(
  parameter int ENV_W      = 8,
  parameter int HOLD_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic [ENV_W-1:0] env_i,
  input  logic             phase_i,
  output logic             lit_o
);

  localparam int               CNT_W   = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_TICKS);

  hold_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gate_q;
  logic             rise;
  logic             env_zero;

  assign rise     = gate_i & ~gate_q;
  assign env_zero = (env_i == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (rise) begin
      st_d  = HS_FULL;
      cnt_d = HOLD_LD;
    end else begin
      unique case (st_q)
        HS_FULL: begin
          if (tick_i) begin
            if (cnt_q <= CNT_W'(1)) begin
              st_d  = env_zero ? HS_OFF : HS_HALF;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
        HS_HALF: begin
          if (env_zero) st_d = HS_OFF;
        end
        default: begin
          st_d = HS_OFF;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_OFF;
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      gate_q <= gate_i;
    end
  end

  assign lit_o = (st_q == HS_FULL) | ((st_q == HS_HALF) & phase_i);

endmodule

// File: rtl/act_led_chan.sv
module act_led_chan #(
  parameter int ENV_W      = 8,
  parameter int HOLD_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic [ENV_W-1:0] env_i,
  input  logic             phase_i,
  input  logic             mode_i,
  input  logic             inv_i,
  output logic             led_o
);

  logic lit_pwm, lit_hold, lit_sel;

  act_led_pwm #(.ENV_W(ENV_W)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .env_i (env_i),
    .lit_o (lit_pwm)
  );

  act_led_hold #(.ENV_W(ENV_W), .HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .gate_i  (gate_i),
    .env_i   (env_i),
    .phase_i (phase_i),
    .lit_o   (lit_hold)
  );

  assign lit_sel = mode_i ? lit_hold : lit_pwm;
  assign led_o   = lit_sel ^ inv_i;

endmodule

// File: rtl/act_led_drv.sv
module act_led_drv #(
  parameter int NVOICE     = 3,
  parameter int ENV_W      = 8,
  parameter int HOLD_TICKS = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [NVOICE*ENV_W-1:0] voice_env_i,
  input  logic [NVOICE-1:0]       voice_gate_i,
  input  logic [ENV_W-1:0]        digi_lvl_i,
  input  logic                    digi_gate_i,
  input  logic                    mode_i,
  input  logic                    inv_i,
  output logic [NVOICE:0]         led_o
);

  localparam int NCH = NVOICE + 1;

  logic [NCH*ENV_W-1:0] env_all;
  logic [NCH-1:0]       gate_all;
  logic                 phase_q;

  assign env_all  = {digi_lvl_i, voice_env_i};
  assign gate_all = {digi_gate_i, voice_gate_i};

  // Shared half-brightness phase, flips every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    act_led_chan #(.ENV_W(ENV_W), .HOLD_TICKS(HOLD_TICKS)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .gate_i  (gate_all[g]),
      .env_i   (env_all[g*ENV_W +: ENV_W]),
      .phase_i (phase_q),
      .mode_i  (mode_i),
      .inv_i   (inv_i),
      .led_o   (led_o[g])
    );
  end

endmodule

// File: rtl/act_led_chk.sv
module act_led_chk #(
  parameter int NCH   = 4,
  parameter int ENV_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_i,
  input logic                 inv_i,
  input logic [NCH*ENV_W-1:0] env_all,
  input logic [NCH-1:0]       gate_all,
  input logic [NCH-1:0]       led_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_ZERO_NEVER_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && !inv_i && $past(env_all[g*ENV_W +: ENV_W]) == '0) |-> !led_o[g]); // R3

    AST_FULL_LEVEL_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && !inv_i && $past(!mode_i && !inv_i)
       && $past(&env_all[g*ENV_W +: ENV_W]) && $past(&env_all[g*ENV_W +: ENV_W], 2))
      |-> (led_o[g] || $past(led_o[g]))); // R2

    AST_RISE_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !inv_i && $past(gate_all[g]) && !$past(gate_all[g], 2))
      |-> led_o[g]); // R5

    AST_DARK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !inv_i && $past(mode_i && !inv_i) && !$past(led_o[g])
       && $past(env_all[g*ENV_W +: ENV_W]) == '0
       && !($past(gate_all[g]) && !$past(gate_all[g], 2)))
      |-> !led_o[g]); // R7
  end

endmodule

bind act_led_drv act_led_chk #(.NCH(NCH), .ENV_W(ENV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .inv_i    (inv_i),
  .env_all  (env_all),
  .gate_all (gate_all),
  .led_o    (led_o)
);

// File: tb/sim_act_led_drv.sv
`timescale 1ns/1ps
module sim_act_led_drv;

  localparam int NV   = 3;
  localparam int NC   = NV + 1;
  localparam int HOLD = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_i;
  logic [NV*8-1:0] voice_env_i;
  logic [NV-1:0] voice_gate_i;
  logic [7:0]    digi_lvl_i;
  logic          digi_gate_i;
  logic          mode_i;
  logic          inv_i;
  logic [NV:0]   led_o;

  logic [7:0] env  [NC];
  logic       gate [NC];

  // reference model state
  int  m_acc [NC];
  bit  m_lp  [NC];
  int  m_st  [NC];   // 0 dark, 1 full, 2 half
  int  m_cnt [NC];
  bit  m_gp  [NC];
  bit  m_ph;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    hits [NC];
  int    cyc = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  assign voice_env_i  = {env[2], env[1], env[0]};
  assign voice_gate_i = {gate[2], gate[1], gate[0]};
  assign digi_lvl_i   = env[3];
  assign digi_gate_i  = gate[3];

  act_led_drv #(.NVOICE(NV), .ENV_W(8), .HOLD_TICKS(HOLD)) u0 (
    .clk, .rst_n, .tick_i, .voice_env_i, .voice_gate_i,
    .digi_lvl_i, .digi_gate_i, .mode_i, .inv_i, .led_o
  );

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_acc[c] = 0; m_lp[c] = 0; m_st[c] = 0; m_cnt[c] = 0; m_gp[c] = 0;
    end
    m_ph = 0;
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      model_reset();
      return;
    end
    for (int c = 0; c < NC; c++) begin
      int s;
      bit r;
      s = m_acc[c] + int'(env[c]);
      m_lp[c]  = (s > 255);
      m_acc[c] = s % 256;
      r = gate[c] && !m_gp[c];
      m_gp[c] = gate[c];
      if (r) begin
        m_st[c] = 1; m_cnt[c] = HOLD;
      end else if (m_st[c] == 1) begin
        if (tick_i) begin
          m_cnt[c]--;
          if (m_cnt[c] == 0) m_st[c] = (env[c] != 0) ? 2 : 0;
        end
      end else if (m_st[c] == 2) begin
        if (env[c] == 0) m_st[c] = 0;
      end
    end
    m_ph = !m_ph;
  endtask

  function automatic bit expect_led(int c);
    bit lit;
    if (!rst_n) lit = 0;
    else if (mode_i) lit = (m_st[c] == 1) || (m_st[c] == 2 && m_ph);
    else lit = m_lp[c];
    return lit ^ inv_i;
  endfunction

  // Inputs are set at a falling edge before calling; compare, then advance one clock
  task automatic step();
    #1;
    for (int c = 0; c < NC; c++) begin
      bit e;
      e = expect_led(c);
      n_chk++;
      if (led_o[c] !== e) begin
        n_fail++;
        $display("FAIL %s ch%0d cycle %0d: actual %b expected %b", req, c, cyc, led_o[c], e);
      end
      if (led_o[c] === 1'b1) hits[c]++;
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      tick_i = ((k % 8) == 7);
      step();
    end
    tick_i = 1'b0;
  endtask

  task automatic check_val(string r, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; mode_i = 1'b0; inv_i = 1'b0;
    for (int c = 0; c < NC; c++) begin env[c] = 8'd0; gate[c] = 1'b0; end
    model_reset();
    @(negedge clk);

    // R1 reset state, both polarities (R9)
    req = "R1"; env[1] = 8'd255; run(3);
    inv_i = 1'b1; req = "R9"; run(2);
    inv_i = 1'b0; env[1] = 8'd0;
    rst_n = 1'b1; req = "R1"; run(2);

    // R2 accumulate mode with distinct levels
    req = "R2";
    env[0] = 8'd0; env[1] = 8'd255; env[2] = 8'd128; env[3] = 8'd37;
    run(40);
    env[3] = 8'd200; env[2] = 8'd1; run(20);

    // R3 duty over 256 cycles
    req = "R3"; env[2] = 8'd128; run(3);
    for (int c = 0; c < NC; c++) hits[c] = 0;
    run(256);
    check_val("R3 level0 lit count", hits[0], 0);
    check_val("R3 level255 lit count", hits[1], 255);
    check_val("R3 level128 lit count", hits[2], 128);

    // R9 inverted drive in accumulate mode
    req = "R9"; inv_i = 1'b1; run(30); inv_i = 1'b0;

    // R5/R6/R7 hold mode
    req = "R5"; mode_i = 1'b1;
    env[0] = 8'd50; env[1] = 8'd0; env[2] = 8'd0; env[3] = 8'd0;
    gate[0] = 1'b1; gate[1] = 1'b1;
    run(20);
    req = "R6"; run(40);
    req = "R7"; run(10);
    env[0] = 8'd0; run(10);
    req = "R9"; inv_i = 1'b1; run(8); inv_i = 1'b0;

    // R8 retrigger during full, half and dark
    req = "R8"; env[2] = 8'd90; gate[2] = 1'b1; run(20);
    gate[2] = 1'b0; run(2); gate[2] = 1'b1; run(60);
    gate[2] = 1'b0; run(3); gate[2] = 1'b1; run(10);
    gate[0] = 1'b0; run(2); gate[0] = 1'b1; env[0] = 8'd7; run(50);

    // R1 sample playback channel
    req = "R1"; env[3] = 8'd200; gate[3] = 1'b1; run(60);
    env[3] = 8'd0; run(6);

    // R4 mode and polarity changes act at once
    req = "R4";
    for (int k = 0; k < 12; k++) begin
      mode_i = ~mode_i; run(3);
      inv_i  = ~inv_i;  run(2);
    end

    finish_run();
  end

endmodule